// File: doc/BRIEF.md
# Self-Clearing Soft Reset Controller

This block lets software reset the configuration logic of a MAC-style peripheral through an ordinary register write. Software sets bit 0 of a control register to ask for a reset. The request stays pending until the transmit and receive DMA engines both report idle, so a reset can never land in the middle of a bus transfer. Once both engines are idle, the block fires a single-cycle internal reset. That pulse returns the peripheral's configuration registers to their defaults. The pending bit then clears on its own.

Software learns the outcome by polling. While bit 0 reads one, the reset has not happened yet. When it reads zero, the reset is done. Management logic and buffer managers do not see this pulse. Three stand-in configuration registers represent the peripheral's register file. They are locked while a request is pending, and they show their defaults once the pulse has fired.

Register map: address 0 is the control register, with the pending bit in bit 0. Addresses 1 to NCFG are the stand-in registers. All other addresses read as zero. The control and status pins are plain levels and carry no handshake.

Top module: `soft_rst_ctrl`

## Requirements
- R1: A write with wdata bit 0 = 1 to address 0 while nothing is pending makes address 0 read 1 from the next cycle.
- R2: A write of 0 to bit 0 of address 0 has no effect. A write of 1 while a request is already pending causes no extra pulse and does not lengthen the request.
- R3: `mac_rst` never rises unless `tx_idle` and `rx_idle` were both high at the previous clock edge while a request was pending. A pending request waits for as long as either flag is low.
- R4: `mac_rst` is high for exactly one cycle. It rises one cycle after the first edge at which the request is pending and both idle flags are high.
- R5: Address 0 bit 0 reads 1 during the pulse cycle and reads 0 from the cycle after the pulse.
- R6: From the cycle after the pulse, stand-in register k (address k, for k = 1..NCFG) reads CFG_BASE + k.
- R7: Writes to the stand-in registers are ignored while a request is pending, and stored otherwise.
- R8: While `rst_n` is low, the pending bit reads 0, every stand-in register reads its default and `mac_rst` is low, regardless of the idle flags.
- R9: Addresses above NCFG read 0, and bits 31..1 of address 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |
| tx_idle | input | 1 | Transmit DMA reports idle |
| rx_idle | input | 1 | Receive DMA reports idle |
| mac_rst | output | 1 | One-cycle internal reset pulse |

## Verification
Suppose the sequencer state goes wrong, for example a request is dropped or fires twice. The bench sees this in the very next cycle as a wrong value of bit 0 at address 0, or as an extra or missing high cycle on `mac_rst`. If the register bank clears at the wrong moment or ignores its lock, the readback differs from the bench model on the next read of that address. Random reads after every edge keep that delay to a few cycles. Idle flags that toggle at random, mixed with writes during pending windows, exercise the gating and locking order.

// File: rtl/srst_pkg.sv
package srst_pkg;
  typedef enum logic [1:0] {
    SR_IDLE  = 2'd0,
    SR_ARMED = 2'd1,
    SR_FIRE  = 2'd2
  } srst_state_e;
endpackage

// File: rtl/srst_seq.sv
module srst_seq
  import srst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tx_idle,
  input  logic rx_idle,
  output logic pending,
  output logic fire
);
  srst_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SR_IDLE:  if (req) state_d = SR_ARMED;
      SR_ARMED: if (tx_idle && rx_idle) state_d = SR_FIRE;
      SR_FIRE:  state_d = SR_IDLE;
      default:  state_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SR_IDLE;
    else        state_q <= state_d;
  end

  assign pending = (state_q != SR_IDLE);
  assign fire    = (state_q == SR_FIRE);

  // R1: a request accepted when idle shows as pending next cycle
  p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && req) |=> pending);
  // R2: a pending request holds until its pulse
  p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !fire) |=> pending);
  // R3: pulse only after both engines idle with a request pending
  p_fire_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire) |-> $past(tx_idle && rx_idle && pending));
  // R4: pulse is one cycle wide
  p_fire_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R5: pending clears right after the pulse
  p_clear_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pending);
endmodule

// File: rtl/srst_cfg_bank.sv
module srst_cfg_bank #(
  parameter int unsigned NCFG     = 3,
  parameter int unsigned DW       = 32,
  parameter logic [31:0] CFG_BASE = 32'h5A00_0010,
  localparam int unsigned IW      = (NCFG > 1) ? $clog2(NCFG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               lock,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      wdata,
  output logic [NCFG*DW-1:0] q
);
  function automatic logic [NCFG*DW-1:0] all_defaults();
    logic [NCFG*DW-1:0] v;
    v = '0;
    for (int k = 0; k < NCFG; k++) v[k*DW +: DW] = DW'(CFG_BASE + 32'(k + 1));
    return v;
  endfunction

  localparam logic [NCFG*DW-1:0] DEF_FLAT = all_defaults();

  for (genvar k = 0; k < NCFG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q[k*DW +: DW] <= DEF_FLAT[k*DW +: DW];
      else if (clr)                             q[k*DW +: DW] <= DEF_FLAT[k*DW +: DW];
      else if (we && !lock && idx == IW'(k))    q[k*DW +: DW] <= wdata;
    end
  end

  // R6: registers hold defaults right after a clear
  p_defaults_after_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == DEF_FLAT));
  // R7: locked bank does not change unless cleared
  p_locked_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !clr) |=> $stable(q));
endmodule

// File: rtl/soft_rst_ctrl.sv
module soft_rst_ctrl #(
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned NCFG     = 3,
  parameter logic [31:0] CFG_BASE = 32'h5A00_0010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          tx_idle,
  input  logic          rx_idle,
  output logic          mac_rst
);
  localparam int unsigned IW = (NCFG > 1) ? $clog2(NCFG) : 1;

  logic               ctrl_hit, cfg_hit, req, pending;
  logic [AW-1:0]      cfg_off;
  logic [NCFG*DW-1:0] cfg_q;

  assign ctrl_hit = wr_en && (wr_addr == '0);
  assign cfg_hit  = wr_en && (wr_addr != '0) && (wr_addr <= AW'(NCFG));
  assign req      = ctrl_hit && wr_data[0];
  assign cfg_off  = wr_addr - AW'(1);

  srst_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .tx_idle (tx_idle),
    .rx_idle (rx_idle),
    .pending (pending),
    .fire    (mac_rst)
  );

  srst_cfg_bank #(
    .NCFG     (NCFG),
    .DW       (DW),
    .CFG_BASE (CFG_BASE)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mac_rst),
    .lock  (pending),
    .we    (cfg_hit),
    .idx   (cfg_off[IW-1:0]),
    .wdata (wr_data),
    .q     (cfg_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data[0] = pending;
    for (int k = 0; k < NCFG; k++) begin
      if (rd_addr == AW'(k + 1)) rd_data = cfg_q[k*DW +: DW];
    end
  end

  // R9: control register upper bits always read zero
  p_ctrl_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0) |-> (rd_data[DW-1:1] == '0));
  // R2: writing zero to an idle controller never starts a request
  p_zero_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && ctrl_hit && !wr_data[0]) |=> !pending);
endmodule

// File: tb/test_soft_rst_ctrl.sv
module test_soft_rst_ctrl;
  localparam logic [31:0] BASE = 32'h5A00_0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_idle = 1'b0;
  logic        rx_idle = 1'b0;
  logic        mac_rst;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  logic        m_pend, m_pulse;
  logic [31:0] m_cfg [3];

  always #10 clk = ~clk;

  soft_rst_ctrl i_soft_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_idle(tx_idle), .rx_idle(rx_idle),
    .mac_rst(mac_rst)
  );

  function automatic logic [31:0] cfg_def(int k);
    return BASE + 32'(k + 1);
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    if (a == 0) return {31'd0, m_pend};
    if (a <= 3) return m_cfg[a-1];
    return 32'd0;
  endfunction

  task automatic model_reset();
    m_pend = 0; m_pulse = 0;
    for (int k = 0; k < 3; k++) m_cfg[k] = cfg_def(k);
  endtask

  task automatic model_step(logic w, logic [3:0] a, logic [31:0] d, logic tx, logic rx);
    if (m_pulse) begin
      m_pulse = 0; m_pend = 0;
      for (int k = 0; k < 3; k++) m_cfg[k] = cfg_def(k);
    end else if (m_pend) begin
      if (tx && rx) m_pulse = 1;
    end else if (w && a == 0 && d[0]) begin
      m_pend = 1;
    end else if (w && a >= 1 && a <= 3) begin
      m_cfg[a-1] = d;
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(logic w, logic [3:0] a, logic [31:0] d, logic tx, logic rx,
                     logic [3:0] ra, string tag);
    @(negedge clk);
    rd_addr = ra;
    #1;
    if (mac_rst) pulses++;
    check(tag, "mac_rst", {31'd0, mac_rst}, {31'd0, m_pulse});
    check(tag, "rd_data", rd_data, exp_read(ra));
    wr_en = w; wr_addr = a; wr_data = d; tx_idle = tx; rx_idle = rx;
    model_step(w, a, d, tx, rx);
  endtask

  task automatic hw_reset(logic tx, logic rx);
    @(negedge clk);
    rst_n = 0; wr_en = 0; tx_idle = tx; rx_idle = rx;
    model_reset();
    #1;
    rd_addr = 0; #1;
    check("R8", "pending in reset", rd_data, 32'd0);
    check("R8", "mac_rst in reset", {31'd0, mac_rst}, 32'd0);
    rd_addr = 2; #1;
    check("R8", "cfg2 in reset", rd_data, cfg_def(1));
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    void'($urandom(32'd1234));
    model_reset();
    hw_reset(1, 1);
    for (int a = 0; a < 6; a++) cyc(0, 0, 0, 1, 1, 4'(a), "R8");

    // R1: request while DMA busy
    cyc(1, 0, 32'h1, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 1, 0, "R1");
    // R3: wait while either engine busy
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, i[0], ~i[0], 0, "R3");
    // R7: cfg write while pending ignored
    cyc(1, 2, 32'hDEAD_BEEF, 0, 0, 2, "R7");
    cyc(0, 0, 0, 0, 0, 2, "R7");
    // R2: second request while pending
    p0 = pulses;
    cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 1, 0, "R4");
    cyc(0, 0, 0, 1, 1, 0, "R4");
    cyc(0, 0, 0, 1, 1, 0, "R5");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 0, "R2");
    check("R2", "pulse count", 32'(pulses - p0), 32'd1);
    // R6: program then reset back to defaults
    cyc(1, 1, 32'h1111_0001, 1, 1, 0, "R7");
    cyc(1, 3, 32'h3333_0003, 1, 1, 1, "R7");
    cyc(0, 0, 0, 1, 1, 3, "R7");
    cyc(1, 0, 32'h1, 1, 1, 1, "R6");
    cyc(0, 0, 0, 1, 1, 1, "R6");
    cyc(0, 0, 0, 1, 1, 1, "R6");
    cyc(0, 0, 0, 1, 1, 3, "R6");
    // R2: write zero does nothing
    p0 = pulses;
    cyc(1, 0, 32'hFFFF_FFFE, 1, 1, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0, "R2");
    check("R2", "zero write pulses", 32'(pulses - p0), 32'd0);
    // R9: unmapped reads
    cyc(0, 0, 0, 1, 1, 4, "R9");
    cyc(0, 0, 0, 1, 1, 15, "R9");
    // R8: hardware reset cancels a pending request
    cyc(1, 1, 32'h0BAD_0001, 0, 0, 0, "R7");
    cyc(1, 0, 32'h1, 0, 0, 1, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R1");
    hw_reset(0, 0);
    p0 = pulses;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 4'(i), "R8");
    check("R8", "no pulse after hw reset", 32'(pulses - p0), 32'd0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic        w;
      logic [3:0]  a, ra;
      logic [31:0] d;
      string       tg;
      w  = ($urandom % 3) == 0;
      a  = 4'($urandom % 6);
      d  = $urandom;
      ra = 4'($urandom % 6);
      tg = (ra == 0) ? "R5" : (ra <= 3) ? "R6" : "R9";
      cyc(w, a, d, ($urandom % 4) != 0, ($urandom % 4) != 0, ra, tg);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule